// File: doc/BRIEF.md
# Write Progress Status Generator

This block forms the byte returned to a host that reads a byte-wide non-volatile memory while a write is pending or running. While the inter-byte load timer runs, or while the internal programming cycle is busy, a read returns a status byte instead of array contents. Outside those windows a read returns the array byte that the surrounding logic presents.

The status byte carries five signals:
- a complemented copy of the top bit of the last byte loaded, so the host can poll for completion;
- a toggle bit that alternates on each status read and restarts at 0 whenever a new internal write begins;
- a load-timer-expired bit;
- a sticky page-abort flag;
- the current write-protection state.

The remaining bit positions read as 0. The read result is registered and is held until the next read strobe.

Top module: `wr_status_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `rd_data` is 0. The toggle state and the abort flag reset to 0.
- R2: A read strobe sampled while `load_tmr_run` and `wr_busy` are both low loads `arr_data` into `rd_data` at that clock edge.
- R3: A read strobe sampled while `load_tmr_run` or `wr_busy` is high returns, in bit 7, the complement of `last_wr_msb`.
- R4: Bit 6 of successive status reads alternates 0,1,0,... The first status read in or after the cycle in which `wr_busy` rises returns 0.
- R5: In a status read, bit 5 is 0 while `load_tmr_run` is high and 1 while `load_tmr_run` is low with `wr_busy` high.
- R6: Bit 1 of a status read is the abort flag. `abort_set` sets the flag from the next cycle onward, and `page_start` clears it. If both are high in one cycle, the set wins. The flag stays set until it is cleared.
- R7: Bit 0 of a status read equals `prot_en`.
- R8: Bits 4, 3 and 2 of a status read are 0.
- R9: With `rd_stb` low, `rd_data` keeps its value.
- R10: Array reads do not advance the toggle. Once a write has completed, further reads return array data and no toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_tmr_run | input | 1 | Inter-byte load timer is running |
| wr_busy | input | 1 | Internal write cycle in progress |
| abort_set | input | 1 | Upper-address change detected during page loading |
| page_start | input | 1 | First byte of a new page load accepted |
| prot_en | input | 1 | Write protection enabled |
| last_wr_msb | input | 1 | Bit 7 of the last byte loaded |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| arr_data | input | DATA_W | Addressed array byte |
| rd_data | output | DATA_W | Registered read result |

## Verification
The assertions assume that the control inputs are held low during reset, so the first edge after reset sees a known previous `wr_busy`. They also assume that `rd_stb` is a single-cycle strobe sampled at the clock edge. The stimulus drives every input at the falling edge, keeps the inputs at 0 while reset is asserted, and includes cycles in which `abort_set` and `page_start` are high together. It also includes read strobes in the very cycle `wr_busy` rises, so that the restart of the toggle is covered.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;

    typedef struct packed {
        logic tog;
        logic busy_prev;
    } tog_state_t;

    typedef struct packed {
        logic flag;
    } abort_state_t;

endpackage

// File: rtl/wsg_toggle.sv
module wsg_toggle
    import wr_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic adv,
    output logic tog_rd
);
    tog_state_t st_d, st_q;
    logic       rise;
    logic       tog_eff;

    always_comb begin
        st_d         = st_q;
        rise         = busy & ~st_q.busy_prev;
        tog_eff      = rise ? 1'b0 : st_q.tog;
        tog_rd       = tog_eff;
        st_d.tog     = adv ? ~tog_eff : tog_eff;
        st_d.busy_prev = busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: without a status read or a new write, the toggle holds
    p_tog_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !busy) |=> (st_q.tog == $past(st_q.tog)));

endmodule

// File: rtl/wsg_abort.sv
module wsg_abort
    import wr_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    abort_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the flag is sticky until a clear arrives
    p_abort_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R6: a set is visible on the next cycle even with a clear present
    p_abort_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/wsg_fmt.sv
module wsg_fmt #(
    parameter int DATA_W = 8
) (
    input  logic              poll_bit,
    input  logic              tog_bit,
    input  logic              tmr_done,
    input  logic              abort_bit,
    input  logic              prot_bit,
    output logic [DATA_W-1:0] status_byte
);
    localparam int POS_POLL  = DATA_W - 1;
    localparam int POS_TOG   = DATA_W - 2;
    localparam int POS_TMR   = DATA_W - 3;
    localparam int POS_ABORT = 1;
    localparam int POS_PROT  = 0;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            if (gi == POS_POLL) begin : g_poll
                assign status_byte[gi] = poll_bit;
            end else if (gi == POS_TOG) begin : g_tog
                assign status_byte[gi] = tog_bit;
            end else if (gi == POS_TMR) begin : g_tmr
                assign status_byte[gi] = tmr_done;
            end else if (gi == POS_ABORT) begin : g_abort
                assign status_byte[gi] = abort_bit;
            end else if (gi == POS_PROT) begin : g_prot
                assign status_byte[gi] = prot_bit;
            end else begin : g_zero
                assign status_byte[gi] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/wr_status_gen.sv
module wr_status_gen #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_tmr_run,
    input  logic              wr_busy,
    input  logic              abort_set,
    input  logic              page_start,
    input  logic              prot_en,
    input  logic              last_wr_msb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MSB = DATA_W - 1;

    logic              status_mode;
    logic              tog_bit;
    logic              abort_flag;
    logic [DATA_W-1:0] status_byte;
    logic [DATA_W-1:0] rd_d, rd_q;

    assign status_mode = load_tmr_run | wr_busy;

    wsg_toggle u_toggle (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (wr_busy),
        .adv    (rd_stb & status_mode),
        .tog_rd (tog_bit)
    );

    wsg_abort u_abort (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (abort_set),
        .clr_i  (page_start),
        .flag_o (abort_flag)
    );

    wsg_fmt #(.DATA_W(DATA_W)) u_fmt (
        .poll_bit    (~last_wr_msb),
        .tog_bit     (tog_bit),
        .tmr_done    (~load_tmr_run),
        .abort_bit   (abort_flag),
        .prot_bit    (prot_en),
        .status_byte (status_byte)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_stb) rd_d = status_mode ? status_byte : arr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R9
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    // R2
    p_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !status_mode) |=> (rd_data == $past(arr_data)));

    // R3
    p_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && status_mode) |=> (rd_data[MSB] == !$past(last_wr_msb)));

    // R4
    p_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && wr_busy && !$past(wr_busy)) |=> (rd_data[MSB-1] == 1'b0));

    // R5
    p_tmr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && status_mode) |=> (rd_data[MSB-2] == !$past(load_tmr_run)));

    // R7
    p_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && status_mode) |=> (rd_data[0] == $past(prot_en)));

    // R8
    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && status_mode) |=> (rd_data[4:2] == 3'b000));

endmodule

// File: tb/wr_status_gen_tb.sv
module wr_status_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_tmr_run = 1'b0;
    logic       wr_busy = 1'b0;
    logic       abort_set = 1'b0;
    logic       page_start = 1'b0;
    logic       prot_en = 1'b0;
    logic       last_wr_msb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    string phase = "R1";

    wr_status_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load_tmr_run(load_tmr_run), .wr_busy(wr_busy),
        .abort_set(abort_set), .page_start(page_start), .prot_en(prot_en),
        .last_wr_msb(last_wr_msb), .rd_stb(rd_stb), .arr_data(arr_data), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    logic [7:0] m_exp = 8'h00;
    bit m_tog = 0, m_ab = 0, m_prev = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_exp = 8'h00; m_tog = 0; m_ab = 0; m_prev = 0;
        end else begin
            if (wr_busy && !m_prev) m_tog = 0;
            if (rd_stb) begin
                if (wr_busy || load_tmr_run) begin
                    m_exp = {~last_wr_msb, m_tog, ~load_tmr_run, 3'b000, m_ab, prot_en};
                    m_tog = ~m_tog;
                end else begin
                    m_exp = arr_data;
                end
            end
            if (abort_set) m_ab = 1;
            else if (page_start) m_ab = 0;
            m_prev = wr_busy;
        end
    end

    always @(negedge clk) begin
        n_chk++;
        if (rd_data !== m_exp) begin
            n_bad++;
            $display("FAIL %s model compare: got %h expected %h", phase, rd_data, m_exp);
        end
    end

    task automatic chk(input string req, input logic [7:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, rd_data, exp);
        end
    endtask

    task automatic rd(input string req, input logic [7:0] exp);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(req, exp);
    endtask

    initial begin : wdog
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 8'h00);

        phase = "R2";
        arr_data = 8'h5A; rd("R2", 8'h5A);
        arr_data = 8'hC3; rd("R2", 8'hC3);

        phase = "R9";
        arr_data = 8'h11;
        @(negedge clk); @(negedge clk);
        chk("R9", 8'hC3);

        phase = "R5";
        prot_en = 1'b1; last_wr_msb = 1'b1; load_tmr_run = 1'b1; page_start = 1'b1;
        @(negedge clk); page_start = 1'b0;
        rd("R5", 8'h01);          // loading: bit5=0, tog 0, bit7=0, prot=1
        abort_set = 1'b1; @(negedge clk); abort_set = 1'b0;
        phase = "R6";
        rd("R6", 8'h43);          // abort visible, toggle advanced to 1
        load_tmr_run = 1'b0; wr_busy = 1'b1;
        phase = "R4";
        rd("R4", 8'h23);          // first read of busy cycle: tog 0, bit5 1
        rd("R4", 8'h63);
        rd("R8", 8'h23);
        abort_set = 1'b1; page_start = 1'b1; @(negedge clk);
        abort_set = 1'b0; page_start = 1'b0;
        phase = "R6";
        rd("R6", 8'h63);          // set wins over clear
        page_start = 1'b1; @(negedge clk); page_start = 1'b0;
        rd("R6", 8'h21);          // cleared
        phase = "R10";
        wr_busy = 1'b0; arr_data = 8'hA5;
        rd("R10", 8'hA5);
        rd("R10", 8'hA5);
        phase = "R3";
        wr_busy = 1'b1; last_wr_msb = 1'b0; prot_en = 1'b0;
        rd("R3", 8'hA0);          // bit7 set, tog restarts 0, prot 0
        rd("R7", 8'hE0);
        prot_en = 1'b1;
        rd("R7", 8'hA1);
        wr_busy = 1'b0;
        @(negedge clk);

        phase = "R4";             // random mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            load_tmr_run = ($urandom % 4) == 0;
            if (($urandom % 8) == 0) wr_busy = ~wr_busy;
            abort_set   = ($urandom % 16) == 0;
            page_start  = ($urandom % 16) == 0;
            prot_en     = $urandom % 2;
            last_wr_msb = $urandom % 2;
            rd_stb      = $urandom % 2;
            arr_data    = 8'($urandom);
            @(negedge clk);
        end
        rd_stb = 1'b0;
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule